// File: doc/BRIEF.md
# Accumulator-Style 8-Bit Teaching Processor

A small processor meant to make datapath and control flow easy to follow. It keeps its program and its data in two separate 32-byte arrays, and it executes one single-byte instruction in each enabled clock cycle. An input register and one operand feed an adder. The sum always goes to a separate output register, and a zero flag is set or cleared from the sum. The instructions cover loading, adding, storing, unconditional and conditional jumps, emitting a data byte as a character, and halting.

The host fills both arrays through preload ports while `run_i` is low. It then either holds `run_i` high to run freely, or pulses it to execute one instruction per pulse. Each executed output instruction produces a one-cycle strobe with the character. A sticky halt indication stays set until reset.

Top module: `tcpu_top`

## Requirements
- R1: While `rst_ni` is low, the PC, input register, output register and zero flag clear to 0, and `halted_o` and `out_valid_o` read 0. The first instruction executed after reset comes from program address 0.
- R2: An instruction byte holds the opcode in bits 7:5 and a 5-bit immediate or address in bits 4:0. The opcodes are 000 add-immediate, 001 add-memory, 010 load-input, 011 store-output, 100 jump, 101 jump-if-zero, 110 output-memory and 111 halt.
- R3: Add-immediate writes input + zero-extended immediate (mod 256) to the output register and leaves the input register unchanged.
- R4: Add-memory writes input + data[addr] (mod 256) to the output register and discards the carry, so adding 0xFF decrements.
- R5: Load-input copies data[addr] into the input register. Store-output writes the output register to data[addr].
- R6: The increment is applied after the jump mux. An instruction that does not jump advances the PC by 1, and a jump to N resumes execution at N+1, so a jump to 0 resumes at 1.
- R7: Jump-if-zero is taken only when the zero flag is 1. Only the two add instructions update the flag (1 when the sum is 0x00). Load, store, output and jump leave it unchanged.
- R8: Output-memory raises `out_valid_o` for exactly one cycle after the executing edge, with `out_char_o` = data[addr]. No other instruction raises it.
- R9: Halt sets `halted_o`, which stays set until reset. While it is set, no instruction executes, so there are no strobes, no memory writes and no PC change.
- R10: While `run_i` is low, nothing executes. Each clock edge with `run_i` high executes exactly one instruction, so pulsed stepping and free running give the same output sequence.
- R11: A preload write places its data byte at the given address of the program array or the data array on the clock edge. If a preload write and a store target the data array in the same cycle, the preload write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Execute one instruction on this edge |
| prog_we_i | input | 1 | Program array preload write enable |
| prog_addr_i | input | 5 | Program array preload address |
| prog_wdata_i | input | 8 | Program array preload data |
| data_we_i | input | 1 | Data array preload write enable |
| data_addr_i | input | 5 | Data array preload address |
| data_wdata_i | input | 8 | Data array preload data |
| out_valid_o | output | 1 | One-cycle character strobe |
| out_char_o | output | 8 | Character from the output instruction |
| halted_o | output | 1 | Sticky halt indication |

## Verification
From the ports it is hardest to observe that the zero flag survives the instructions between an add and the conditional jump that reads it, and that a jump lands one slot past its target. The programs are laid out so that the slot at the nominal target, and any slot reached by a wrong branch decision, holds an output instruction that emits a character the scoreboard never expects. In one program, a counter loop exits through a jump-if-zero that follows a load. A second program jumps to address 0, whose output instruction must not execute a second time. The first program is also run in pulsed single-step mode to show that the output sequence does not depend on `run_i` timing.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  typedef enum logic [2:0] {
    OP_ADI = 3'b000,
    OP_ADM = 3'b001,
    OP_LDI = 3'b010,
    OP_STO = 3'b011,
    OP_JMP = 3'b100,
    OP_JPZ = 3'b101,
    OP_OUT = 3'b110,
    OP_HLT = 3'b111
  } op_e;
endpackage

// File: rtl/tcpu_mem.sv
module tcpu_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // preload port has priority over the core write port
  always_ff @(posedge clk_i) begin
    if (ld_we_i)      mem_q[ld_addr_i] <= ld_data_i;
    else if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  p_preload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_i |=> mem_q[$past(ld_addr_i)] == $past(ld_data_i));

  p_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ld_we_i) |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              zero_o
);
  // carry out is dropped on purpose
  assign sum_o  = a_i + b_i;
  assign zero_o = (sum_o == '0);
endmodule

// File: rtl/tcpu_top.sv
module tcpu_top
  import tcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_wdata_i,
  input  logic              data_we_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_char_o,
  output logic              halted_o
);
  localparam int OP_W  = DATA_W - ADDR_W;
  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, pc_next, imm;
  logic [DATA_W-1:0] in_q, out_q, char_q;
  logic              zero_q, halted_q, strobe_q;
  logic [DATA_W-1:0] instr, dmem_rd, alu_b, alu_sum;
  logic              alu_zero, exec, jump_taken, is_add;
  logic [OP_W-1:0]   op_bits;
  op_e               op;

  tcpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_prog_mem (
    .clk_i, .rst_ni,
    .ld_we_i(prog_we_i), .ld_addr_i(prog_addr_i), .ld_data_i(prog_wdata_i),
    .wr_en_i(1'b0), .wr_addr_i('0), .wr_data_i('0),
    .rd_addr_i(pc_q), .rd_data_o(instr)
  );

  assign op_bits = instr[DATA_W-1:ADDR_W];
  assign op      = op_e'(op_bits);
  assign imm     = instr[ADDR_W-1:0];
  assign exec    = run_i && !halted_q;

  tcpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_data_mem (
    .clk_i, .rst_ni,
    .ld_we_i(data_we_i), .ld_addr_i(data_addr_i), .ld_data_i(data_wdata_i),
    .wr_en_i(exec && op == OP_STO), .wr_addr_i(imm), .wr_data_i(out_q),
    .rd_addr_i(imm), .rd_data_o(dmem_rd)
  );

  assign alu_b = (op == OP_ADI) ? {{EXT_W{1'b0}}, imm} : dmem_rd;

  tcpu_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i(in_q), .b_i(alu_b), .sum_o(alu_sum), .zero_o(alu_zero)
  );

  assign is_add     = (op == OP_ADI) || (op == OP_ADM);
  assign jump_taken = (op == OP_JMP) || (op == OP_JPZ && zero_q);
  // increment sits after the target mux
  assign pc_next    = (jump_taken ? imm : pc_q) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      in_q     <= '0;
      out_q    <= '0;
      zero_q   <= 1'b0;
      halted_q <= 1'b0;
      strobe_q <= 1'b0;
      char_q   <= '0;
    end else begin
      strobe_q <= exec && (op == OP_OUT);
      if (exec) begin
        if (op != OP_HLT) pc_q <= pc_next;
        case (op)
          OP_ADI, OP_ADM: begin
            out_q  <= alu_sum;
            zero_q <= alu_zero;
          end
          OP_LDI:  in_q     <= dmem_rd;
          OP_OUT:  char_q   <= dmem_rd;
          OP_HLT:  halted_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign out_valid_o = strobe_q;
  assign out_char_o  = char_q;
  assign halted_o    = halted_q;

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q);
  p_halt_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> ($stable(pc_q) && !out_valid_o));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(pc_q) && $stable(in_q) && $stable(out_q) && $stable(zero_q)));
  p_seq_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !jump_taken && op != OP_HLT) |=> pc_q == $past(pc_q) + 1'b1);
  p_jump_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && jump_taken) |=> pc_q == $past(imm) + 1'b1);
  p_in_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && is_add) |=> $stable(in_q));
  p_zero_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec && is_add) |=> $stable(zero_q));
  p_strobe_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(exec && op == OP_OUT));
endmodule

// File: tb/test_tcpu_top.sv
`timescale 1ns/1ps
module test_tcpu_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       prog_we_i = 1'b0, data_we_i = 1'b0;
  logic [4:0] prog_addr_i = '0, data_addr_i = '0;
  logic [7:0] prog_wdata_i = '0, data_wdata_i = '0;
  logic       out_valid_o, halted_o;
  logic [7:0] out_char_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] exp_q [$];
  logic [7:0] prog_img [32];
  logic [7:0] data_img [32];

  always #4 clk_i = ~clk_i;

  tcpu_top i_tcpu_top (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each strobe
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) check(0, "R8/R9 unexpected strobe", out_char_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(out_char_o == e, "R8 character", out_char_o, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(halted_o == 1'b0, "R1 halted after reset", halted_o, 0);
    check(out_valid_o == 1'b0, "R1 strobe after reset", out_valid_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic preload();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      prog_we_i = 1'b1; prog_addr_i = 5'(i); prog_wdata_i = prog_img[i];
      data_we_i = 1'b1; data_addr_i = 5'(i); data_wdata_i = data_img[i];
    end
    @(negedge clk_i); prog_we_i = 1'b0; data_we_i = 1'b0;
  endtask

  task automatic expect_char(input logic [7:0] c);
    exp_q.push_back(c);
  endtask

  task automatic run_prog(input bit stepped);
    for (int c = 0; c < 400 && !halted_o; c++) begin
      run_i = 1'b1; @(negedge clk_i);
      if (stepped) begin run_i = 1'b0; @(negedge clk_i); end
    end
    run_i = 1'b0;
    check(halted_o == 1'b1, "R9 halted reached", halted_o, 1);
    repeat (6) @(negedge clk_i);
    run_i = 1'b1; repeat (10) @(negedge clk_i); run_i = 1'b0;
    check(halted_o == 1'b1, "R9 halt sticky", halted_o, 1);
    check(exp_q.size() == 0, "R6/R7/R8 all characters seen", exp_q.size(), 0);
  endtask

  task automatic load_prog_a();
    logic [7:0] p [25] = '{8'hC1, 8'h05, 8'h64, 8'hC4, 8'h41, 8'h01, 8'h61, 8'h02,
                           8'h65, 8'hC1, 8'hC5, 8'h42, 8'h23, 8'h63, 8'hC3, 8'hB1,
                           8'h8A, 8'hC2, 8'h44, 8'hB5, 8'hC2, 8'hC2, 8'hC1, 8'hE0,
                           8'hC1};
    for (int i = 0; i < 32; i++) begin
      prog_img[i] = (i < 25) ? p[i] : 8'hE0;
      data_img[i] = 8'h00;
    end
    data_img[1] = 8'h41; data_img[2] = 8'hFF; data_img[3] = 8'h03;
  endtask

  task automatic queue_prog_a();
    expect_char(8'h41); // R1 first fetch from 0
    expect_char(8'h05); // R1 input reg cleared, R3 immediate add, R5 store
    expect_char(8'h42); // R5 load then store
    expect_char(8'h43); // R3 input register unchanged by add
    expect_char(8'h02); // R4 add 0xFF decrements, carry dropped
    expect_char(8'h01); // R7 not-taken jump-if-zero, R6 loop jump
    expect_char(8'h00); // R7 zero exit
    expect_char(8'h42); // R7 flag kept across load, R6 target+1
  endtask

  initial begin : watchdog
    #(8ns * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    load_prog_a();
    do_reset();
    preload();
    // R10: nothing executes with run_i low
    repeat (12) begin
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R10 idle strobe", out_valid_o, 0);
    end
    check(halted_o == 1'b0, "R10 idle halted", halted_o, 0);
    queue_prog_a();
    run_prog(1'b0);

    // R10: same program in pulsed step mode
    load_prog_a();
    do_reset();
    preload();
    queue_prog_a();
    run_prog(1'b1);

    // Program B: jump to 0 resumes at 1, immediate add wrap
    for (int i = 0; i < 32; i++) begin prog_img[i] = 8'hE0; data_img[i] = 8'h00; end
    prog_img[0] = 8'hC6; prog_img[1] = 8'h49; prog_img[2] = 8'h1F; prog_img[3] = 8'h69;
    prog_img[4] = 8'hC9; prog_img[5] = 8'hA7; prog_img[6] = 8'h80; prog_img[7] = 8'hC6;
    prog_img[8] = 8'hE0;
    data_img[6] = 8'h5A; data_img[9] = 8'hC2;
    do_reset();
    preload();
    expect_char(8'h5A); // R6 only once: jump to 0 resumes at 1
    expect_char(8'hE1); // R2 field decode, R3 immediate 31
    expect_char(8'h00); // R3 carry discarded, R7 taken
    run_prog(1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule